// File: doc/BRIEF.md
# Parity-Guarded Two-Way Instruction Cache

This block is a two-way set-associative instruction cache that sits between a fetch unit and a next-level memory. Each line holds one instruction word. The cache keeps each tag and each data word together with one even-parity bit. Both parity bits are written when a line is filled. Both are checked on every lookup of a valid way. A fetch that hits returns the word in the cycle after it is accepted. A fetch that misses raises a refill request to the next level, writes the returned word into the victim way of its set, and then repeats the lookup.

When either way of the addressed set shows a parity mismatch, the cache does not just skip the bad way. It invalidates both ways of the set and pulses an error report that carries the set index. It then refetches the requested line and repeats the lookup. Each set has one toggle bit that picks the victim on a fill. A fault-injection port models bitcell upsets by flipping chosen stored bits.

One parity bit per word detects any odd number of flipped bits. An even number of flipped bits is not detected, so a double-bit upset in a data word returns the corrupted word without any error report.

Top module: `icp_cache`

## Requirements
- R1: After reset is released, no way of any set is valid, `req_ready_o` is 1, and `rsp_valid_o`, `fill_req_o` and `err_o` are 0. A reset later in operation also discards every cached line.
- R2: On a miss, `fill_req_o` rises in the cycle after the lookup cycle. It stays high with `fill_addr_o` equal to the full requested address until the cycle in which `fill_rsp_valid_i` is high.
- R3: A fetch that hits gives `rsp_valid_o` for one cycle, in the cycle after the request is accepted. `rsp_data_o` holds the stored word, and no refill is requested.
- R4: Each set has a victim toggle that is 0 after reset. A fill writes way 0 when the toggle is 0 and way 1 when it is 1, and the toggle flips after each fill. Filling a third tag into a set therefore evicts the oldest of the two resident tags.
- R5: A single flipped bit in the stored 31-bit tag of a valid way makes the lookup pulse `err_o` for one cycle with `err_set_o` equal to the set index. The cache then requests a refill of the requested address and answers with the refilled word.
- R6: A single flipped bit in the stored 20-bit data word of a valid way triggers the same recovery as R5: an error pulse, a refill, and a response with the refill data.
- R7: The recovery invalidates both ways of the set, so a line that was resident in the other way misses on its next fetch.
- R8: Two flipped bits in the same stored data word are not detected. The fetch hits without `err_o` or a refill and returns the stored word with both bits flipped.
- R9: `req_ready_o` is 0 from the cycle after acceptance up to and including the response cycle, and no other request is taken in that time.
- R10: A parity error in the way whose tag does not match the request still triggers the full recovery, even when the other way holds the requested line.
- R11: After a refill response the repeated lookup hits. `rsp_valid_o` is high in the next cycle with the refill data, and `err_o` stays 0.
- R12: Fault injection (`inj_i`) takes effect only while `req_ready_o` is 1. In that case it XORs `inj_tag_mask_i` into the stored tag and `inj_data_mask_i` into the stored data of way `inj_way_i` in set `inj_set_i`. The parity bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| req_addr_i | input | ADDR_W (34) | Fetch address, {tag, set index} |
| req_ready_o | output | 1 | Cache can accept a request |
| rsp_valid_o | output | 1 | Fetch response valid, one cycle |
| rsp_data_o | output | DATA_W (20) | Fetched word |
| fill_req_o | output | 1 | Refill request to next level |
| fill_addr_o | output | ADDR_W (34) | Refill address |
| fill_rsp_valid_i | input | 1 | Refill data valid |
| fill_rsp_data_i | input | DATA_W (20) | Refill word |
| err_o | output | 1 | Parity error report pulse |
| err_set_o | output | IDX_W (3) | Set index of the reported error |
| inj_i | input | 1 | Fault-injection strobe |
| inj_way_i | input | 1 | Way to corrupt |
| inj_set_i | input | IDX_W (3) | Set to corrupt |
| inj_tag_mask_i | input | TAG_W (31) | Bits to flip in the stored tag |
| inj_data_mask_i | input | DATA_W (20) | Bits to flip in the stored data |

## Verification
The hardest case to reach from the ports is a parity error in the way that does not hold the requested line while the other way is a clean hit (R10). A normal fill never writes bad parity, so the bench first places two tags in one set through misses. It then corrupts the stored word of the non-matching way through the injection port while the cache is idle, and finally fetches the clean line. The bench expects an error pulse and a refill instead of a hit. A follow-up fetch of the other line must miss, which shows that the whole set was cleared.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } icp_state_e;
endpackage

// File: rtl/icp_parity.sv
module icp_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         par_o
);
  assign par_o = ^d_i;
endmodule

// File: rtl/icp_way.sv
module icp_way #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 31,
  parameter int DATA_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inv_i,
  input  logic              inj_i,
  input  logic [IDX_W-1:0]  inj_idx_i,
  input  logic [TAG_W-1:0]  inj_tmask_i,
  input  logic [DATA_W-1:0] inj_dmask_i,
  output logic              hit_o,
  output logic              perr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];
  logic [SETS-1:0]   tpar_q, dpar_q, vld_q;
  logic tgen, dgen, tchk, dchk;

  icp_parity #(.W(TAG_W))  u_tgen (.d_i(tag_i),          .par_o(tgen));
  icp_parity #(.W(DATA_W)) u_dgen (.d_i(wdata_i),        .par_o(dgen));
  icp_parity #(.W(TAG_W))  u_tchk (.d_i(tag_q[idx_i]),   .par_o(tchk));
  icp_parity #(.W(DATA_W)) u_dchk (.d_i(dat_q[idx_i]),   .par_o(dchk));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (wr_i) begin
      vld_q[idx_i] <= 1'b1;
    end else if (inv_i) begin
      vld_q[idx_i] <= 1'b0;
    end
  end

  // arrays carry no reset; validity gates every use
  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_q[idx_i]  <= tag_i;
      dat_q[idx_i]  <= wdata_i;
      tpar_q[idx_i] <= tgen;
      dpar_q[idx_i] <= dgen;
    end else if (inj_i) begin
      tag_q[inj_idx_i] <= tag_q[inj_idx_i] ^ inj_tmask_i;
      dat_q[inj_idx_i] <= dat_q[inj_idx_i] ^ inj_dmask_i;
    end
  end

  assign hit_o   = vld_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign perr_o  = vld_q[idx_i] && ((tchk ^ tpar_q[idx_i]) || (dchk ^ dpar_q[idx_i]));
  assign rdata_o = dat_q[idx_i];
endmodule

// File: rtl/icp_cache.sv
module icp_cache
  import icp_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int SETS   = 8,
  parameter int DATA_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_rsp_valid_i,
  input  logic [DATA_W-1:0] fill_rsp_data_i,
  output logic              err_o,
  output logic [IDX_W-1:0]  err_set_o,
  input  logic              inj_i,
  input  logic              inj_way_i,
  input  logic [IDX_W-1:0]  inj_set_i,
  input  logic [TAG_W-1:0]  inj_tag_mask_i,
  input  logic [DATA_W-1:0] inj_data_mask_i
);
  localparam int WAYS = 2;

  icp_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SETS-1:0]   tog_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   hit, perr;
  logic [DATA_W-1:0] rd [WAYS];
  logic              any_err, any_hit, look, fill_go;

  assign idx     = addr_q[IDX_W-1:0];
  assign tag     = addr_q[ADDR_W-1:IDX_W];
  assign look    = (state_q == ST_LOOK);
  assign any_err = |perr;
  assign any_hit = |hit;
  assign fill_go = (state_q == ST_FILL) && fill_rsp_valid_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    icp_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .idx_i       (idx),
      .tag_i       (tag),
      .wr_i        (fill_go && (tog_q[idx] == 1'(w))),
      .wdata_i     (fill_rsp_data_i),
      .inv_i       (err_o),
      .inj_i       (inj_i && req_ready_o && (inj_way_i == 1'(w))),
      .inj_idx_i   (inj_set_i),
      .inj_tmask_i (inj_tag_mask_i),
      .inj_dmask_i (inj_data_mask_i),
      .hit_o       (hit[w]),
      .perr_o      (perr[w]),
      .rdata_o     (rd[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tog_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: state_q <= (any_err || !any_hit) ? ST_FILL : ST_IDLE;
        ST_FILL: if (fill_rsp_valid_i) begin
          tog_q[idx] <= ~tog_q[idx];
          state_q    <= ST_LOOK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = look && !any_err && any_hit;
  assign rsp_data_o  = !rsp_valid_o ? '0 : (hit[1] ? rd[1] : rd[0]);
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = addr_q;
  assign err_o       = look && any_err;
  assign err_set_o   = idx;
endmodule

// File: rtl/icp_cache_chk.sv
module icp_cache_chk #(
  parameter int ADDR_W = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              fill_req_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              fill_rsp_valid_i,
  input logic              err_o
);
  // R9
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (rsp_valid_o || fill_req_o)));

  // R2
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_rsp_valid_i |=> fill_req_o && $stable(fill_addr_o));

  // R5
  err_refill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> fill_req_o && !rsp_valid_o);

  // R5
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R11
  replay_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && fill_rsp_valid_i |=> rsp_valid_o && !err_o);

  // R6
  err_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && rsp_valid_o));
endmodule

bind icp_cache icp_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_ready_o      (req_ready_o),
  .rsp_valid_o      (rsp_valid_o),
  .fill_req_o       (fill_req_o),
  .fill_addr_o      (fill_addr_o),
  .fill_rsp_valid_i (fill_rsp_valid_i),
  .err_o            (err_o)
);

// File: tb/icp_cache_bench.sv
module icp_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 34;
  localparam int SETS   = 8;
  localparam int DATA_W = 20;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = 31;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] fd;
    logic              miss;
    logic [DATA_W-1:0] exp;
  } vec_t;

  localparam logic [TAG_W-1:0] TA = 31'h0ABC_0001;
  localparam logic [TAG_W-1:0] TB = 31'h0ABC_0002;
  localparam logic [TAG_W-1:0] TC = 31'h1234_5678;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{TA, 3'd1, 20'h11111, 1'b1, 20'h11111},
    '{TA, 3'd1, 20'h00000, 1'b0, 20'h11111},
    '{TB, 3'd1, 20'h22222, 1'b1, 20'h22222},
    '{TA, 3'd1, 20'h00000, 1'b0, 20'h11111},
    '{TB, 3'd1, 20'h00000, 1'b0, 20'h22222},
    '{TC, 3'd1, 20'h33333, 1'b1, 20'h33333},
    '{TB, 3'd1, 20'h00000, 1'b0, 20'h22222},
    '{TA, 3'd1, 20'h44444, 1'b1, 20'h44444},
    '{TC, 3'd5, 20'h55555, 1'b1, 20'h55555},
    '{TC, 3'd5, 20'h00000, 1'b0, 20'h55555}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              req_ready_o, rsp_valid_o, fill_req_o, err_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic [ADDR_W-1:0] fill_addr_o;
  logic              fill_rsp_valid_i = 1'b0;
  logic [DATA_W-1:0] fill_rsp_data_i = '0;
  logic [IDX_W-1:0]  err_set_o;
  logic              inj_i = 1'b0;
  logic              inj_way_i = 1'b0;
  logic [IDX_W-1:0]  inj_set_i = '0;
  logic [TAG_W-1:0]  inj_tag_mask_i = '0;
  logic [DATA_W-1:0] inj_data_mask_i = '0;

  int checks = 0;
  int errors = 0;

  // fetch results
  logic [DATA_W-1:0] r_data;
  logic              r_filled, r_err, r_done, r_busy_ok;
  logic [IDX_W-1:0]  r_eset;
  logic [ADDR_W-1:0] r_faddr;
  int                r_nfill, r_nrsp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  icp_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .DATA_W(DATA_W)) u_icp_cache (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .rsp_valid_o, .rsp_data_o, .fill_req_o, .fill_addr_o,
    .fill_rsp_valid_i, .fill_rsp_data_i, .err_o, .err_set_o,
    .inj_i, .inj_way_i, .inj_set_i, .inj_tag_mask_i, .inj_data_mask_i
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] ix,
                       input logic [DATA_W-1:0] fd);
    r_data = '0; r_filled = 0; r_err = 0; r_done = 0; r_busy_ok = 1;
    r_eset = '0; r_faddr = '0; r_nfill = -1; r_nrsp = -1;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = {t, ix};
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_addr_i  = '0;
    for (int n = 0; n < 16 && !r_done; n++) begin
      fill_rsp_valid_i = 1'b0;
      if (req_ready_o) r_busy_ok = 0;
      if (err_o) begin r_err = 1; r_eset = err_set_o; end
      if (rsp_valid_o) begin
        r_data = rsp_data_o; r_nrsp = n; r_done = 1;
      end else if (fill_req_o) begin
        r_filled = 1; r_faddr = fill_addr_o; r_nfill = n;
        fill_rsp_valid_i = 1'b1; fill_rsp_data_i = fd;
      end
      if (!r_done) @(negedge clk_i);
    end
    fill_rsp_valid_i = 1'b0;
  endtask

  task automatic inject(input logic w, input logic [IDX_W-1:0] s,
                        input logic [TAG_W-1:0] tm, input logic [DATA_W-1:0] dm);
    @(negedge clk_i);
    inj_i = 1'b1; inj_way_i = w; inj_set_i = s;
    inj_tag_mask_i = tm; inj_data_mask_i = dm;
    @(negedge clk_i);
    inj_i = 1'b0; inj_tag_mask_i = '0; inj_data_mask_i = '0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(req_ready_o && !rsp_valid_o && !fill_req_o && !err_o, "R1 idle after reset",
          {req_ready_o, rsp_valid_o, fill_req_o, err_o}, 4'b1000);

    // table walk: R2 R3 R4 R9 R11
    for (int i = 0; i < NV; i++) begin
      fetch(VECS[i].tag, VECS[i].idx, VECS[i].fd);
      check(r_done && r_data == VECS[i].exp, "R3/R4 response data", r_data, VECS[i].exp);
      check(r_filled == VECS[i].miss, "R4 miss/hit pattern", r_filled, VECS[i].miss);
      check(!r_err, "R2 no error on clean lines", r_err, 0);
      check(r_busy_ok, "R9 ready low while busy", r_busy_ok, 1);
      if (VECS[i].miss) begin
        check(r_faddr == {VECS[i].tag, VECS[i].idx}, "R2 refill address",
              r_faddr, {VECS[i].tag, VECS[i].idx});
        check(r_nrsp == r_nfill + 1, "R11 replay one cycle after refill", r_nrsp, r_nfill + 1);
      end else begin
        check(r_nrsp == 0, "R3 hit latency", r_nrsp, 0);
      end
    end

    // set1: way0=C(33333) way1=A(44444), toggle 0
    // R6 single data bit in way0
    inject(1'b0, 3'd1, '0, 20'h00001);
    fetch(TC, 3'd1, 20'h66666);
    check(r_err && r_eset == 3'd1, "R6 error pulse with set", {r_err, r_eset}, {1'b1, 3'd1});
    check(r_filled && r_data == 20'h66666, "R6 refetch data", r_data, 20'h66666);
    check(r_nrsp == r_nfill + 1, "R11 replay after recovery", r_nrsp, r_nfill + 1);

    // R7 A was in way1, must miss now
    fetch(TA, 3'd1, 20'h77777);
    check(r_filled && !r_err && r_data == 20'h77777, "R7 other way invalidated",
          {r_filled, r_err, r_data}, {1'b1, 1'b0, 20'h77777});

    // R5 single tag bit in way1 (A)
    inject(1'b1, 3'd1, 31'h4000_0000, '0);
    fetch(TA, 3'd1, 20'h88888);
    check(r_err && r_eset == 3'd1 && r_filled, "R5 tag flip recovery",
          {r_err, r_eset, r_filled}, {1'b1, 3'd1, 1'b1});
    check(r_data == 20'h88888, "R5 refetch data", r_data, 20'h88888);

    // way0=A(88888); bring C into way1
    fetch(TC, 3'd1, 20'h99999);
    check(r_filled && r_data == 20'h99999, "R4 fill second way", r_data, 20'h99999);

    // R10 error in non-matching way1 (C) while A hits in way0
    inject(1'b1, 3'd1, '0, 20'h00010);
    fetch(TA, 3'd1, 20'hAAAAA);
    check(r_err && r_filled, "R10 error in other way recovers", {r_err, r_filled}, 2'b11);
    check(r_data == 20'hAAAAA, "R10 refetch data", r_data, 20'hAAAAA);
    fetch(TC, 3'd1, 20'h12345);
    check(r_filled && !r_err, "R7 set wiped after R10", {r_filled, r_err}, 2'b10);

    // R8 double flip in way1 (C) undetected
    inject(1'b1, 3'd1, '0, 20'h00003);
    fetch(TC, 3'd1, 20'h0);
    check(!r_err && !r_filled, "R8 double flip not detected", {r_err, r_filled}, 2'b00);
    check(r_data == 20'h12346, "R8 corrupted data returned", r_data, 20'h12346);

    // R12 injection during busy ignored: inject while fetch of set5 is in refill
    fork
      fetch(TB, 3'd5, 20'h0BBBB);
      begin
        @(negedge clk_i); @(negedge clk_i);
        inj_i = 1'b1; inj_way_i = 1'b0; inj_set_i = 3'd5; inj_data_mask_i = 20'h00001;
        @(negedge clk_i);
        inj_i = 1'b0; inj_data_mask_i = '0;
      end
    join
    check(r_filled && !r_err && r_data == 20'h0BBBB, "R12 fill unaffected", r_data, 20'h0BBBB);
    fetch(TC, 3'd5, 20'h0);
    check(!r_err && !r_filled && r_data == 20'h55555, "R12 busy injection ignored",
          {r_err, r_filled, r_data}, {1'b0, 1'b0, 20'h55555});

    // R1 reset mid-run discards lines
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    fetch(TC, 3'd5, 20'h0CCCC);
    check(r_filled && r_data == 20'h0CCCC, "R1 reset invalidates", r_filled, 1);

    summary();
    $finish;
  end
endmodule